// File: doc/BRIEF.md
# Byte Access Unit over Word-Only Memory

This unit lets a client perform single-byte loads and stores against a memory that can only move whole 32-bit words. Every request carries a split address: the word address, plus a separate bit offset that selects one of the four byte lanes and serves directly as the shift count. A load fetches the word, shifts it right by the offset and returns the low byte.

A store is a read-modify-write. The unit fetches the word, clears the target lane with a shifted mask, and merges the new byte into that lane. It then writes the word back with a compare-exchange against the value it read. Another agent may change a neighbouring byte between the read and the write. In that case the exchange fails and the memory returns the word's current contents. The unit then redoes the merge on that fresh word and tries again, until the exchange succeeds. No fence or barrier is ever issued.

Only one request is in flight at a time. Both the client side and the response side use valid/ready handshakes. The memory port accepts a command in any cycle and answers exactly one cycle later.

Top module: `subword_rmw`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_cmd_valid` is 0.
- R2: Lanes are little-endian: lane k sits in word bits 8k+7..8k and is chosen by bit offset 8k. A load returns `(word >> offset) & 0xFF` on `rsp_data`, with `rsp_err` = 0.
- R3: A load issues exactly one memory command, a read (`mem_cmd_cas` = 0), and never a compare-exchange.
- R4: A store writes back a word in which only the target lane holds the new byte and the other three lanes keep the value that was read.
- R5: Only bits 7..0 of `req_data` are used by a store. Any set upper bits leave the neighbouring lanes untouched.
- R6: A store's compare-exchange sends the most recently returned word on `mem_cmp`. On failure (`mem_cas_ok` = 0), the unit merges again into the returned word and retries until success. The final word keeps every concurrent change made to other lanes.
- R7: An offset that is not a multiple of 8, or that is 32 or more, completes with `rsp_err` = 1. It issues no memory command and leaves memory unchanged.
- R8: `req_ready` stays low from acceptance until the response has been taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_err` hold steady.
- R9: A successful store answers with `rsp_err` = 0 and `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_bitoff | input | OFF_W | Bit offset inside the word |
| req_data | input | 32 | Store data (low byte used) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_data | output | 8 | Loaded byte, 0 for stores |
| rsp_err | output | 1 | Illegal offset |
| mem_cmd_valid | output | 1 | Memory command this cycle |
| mem_cmd_cas | output | 1 | 0 = read, 1 = compare-exchange |
| mem_addr | output | ADDR_W | Word address for the command |
| mem_cmp | output | 32 | Expected word for compare-exchange |
| mem_wdata | output | 32 | New word for compare-exchange |
| mem_rsp_valid | input | 1 | Memory answer, one cycle after the command |
| mem_rdata | input | 32 | Read data, or current word on exchange failure |
| mem_cas_ok | input | 1 | Compare-exchange succeeded |

## Verification
The bench walks a load through all four lanes, so a reversed lane order or a wrong shift shows up as the wrong byte. It stores with the upper data bits set; a design that did not zero them would smear ones into the neighbouring lanes. Its memory model changes a different lane just before the first two exchanges. A unit that compared against a stale word, or wrote its first merge without retrying, would either never finish or would erase the concurrent change. Misaligned and out-of-range offsets are also sent, and any memory traffic or a clear error flag there counts as a failure.

// File: rtl/subword_rmw.sv
module subword_rmw #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [OFF_W-1:0]  req_bitoff,
  input  logic [31:0]       req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              rsp_err,
  output logic              mem_cmd_valid,
  output logic              mem_cmd_cas,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_cmp,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_cas_ok
);
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int SH_W   = $clog2(WORD_W);
  localparam int ALN_W  = $clog2(LANE_W);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MERGE, S_CAS, S_DONE} state_t;

  state_t              state;
  logic [ADDR_W-1:0]   addr_q;
  logic [SH_W-1:0]     sh_q;
  logic [LANE_W-1:0]   byte_q;
  logic                store_q;
  logic                sent_q;
  logic [WORD_W-1:0]   word_q;
  logic [LANE_W-1:0]   out_q;
  logic                err_q;

  logic              off_ok;
  logic [WORD_W-1:0] lane_mask, lane_new, rd_shift;

  assign off_ok    = (req_bitoff[ALN_W-1:0] == '0) && (int'(req_bitoff) < WORD_W);
  assign lane_mask = {{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << sh_q;
  assign lane_new  = {{(WORD_W-LANE_W){1'b0}}, byte_q} << sh_q;
  assign rd_shift  = mem_rdata >> sh_q;

  assign req_ready     = (state == S_IDLE);
  assign rsp_valid     = (state == S_DONE);
  assign rsp_data      = out_q;
  assign rsp_err       = err_q;
  assign mem_cmd_valid = (state == S_READ && !sent_q) || (state == S_MERGE);
  assign mem_cmd_cas   = (state == S_MERGE);
  assign mem_addr      = addr_q;
  assign mem_cmp       = word_q;
  assign mem_wdata     = (word_q & ~lane_mask) | lane_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      store_q <= 1'b0;
      sent_q  <= 1'b0;
      word_q  <= '0;
      out_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          sh_q    <= req_bitoff[SH_W-1:0];
          byte_q  <= req_data[LANE_W-1:0];
          store_q <= req_store;
          sent_q  <= 1'b0;
          out_q   <= '0;
          err_q   <= !off_ok;
          state   <= off_ok ? S_READ : S_DONE;
        end
        S_READ: begin
          sent_q <= 1'b1;
          if (sent_q && mem_rsp_valid) begin
            word_q <= mem_rdata;
            if (store_q) state <= S_MERGE;
            else begin
              out_q <= rd_shift[LANE_W-1:0];
              state <= S_DONE;
            end
          end
        end
        S_MERGE: state <= S_CAS;
        S_CAS: if (mem_rsp_valid) begin
          if (mem_cas_ok) state <= S_DONE;
          else begin
            word_q <= mem_rdata;
            state  <= S_MERGE;
          end
        end
        S_DONE: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_bad_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !off_ok) |=> (rsp_valid && rsp_err && !mem_cmd_valid));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_cmd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |=> !mem_cmd_valid);

  assert_load_no_cas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_cas) |-> store_q);

  assert_keep_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_cas) |-> (((mem_wdata ^ mem_cmp) & ~lane_mask) == '0));

  assert_lane_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_cas) |-> ((mem_wdata & lane_mask) >> sh_q) == WORD_W'(byte_q));
endmodule

// File: tb/subword_rmw_tb.sv
module subword_rmw_tb;
  localparam int ADDR_W = 10;
  localparam int OFF_W  = 6;

  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic              req_valid = 0, req_store = 0, rsp_ready = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [OFF_W-1:0]  req_bitoff = '0;
  logic [31:0]       req_data = '0;
  logic              req_ready, rsp_valid, rsp_err;
  logic [7:0]        rsp_data;
  logic              mem_cmd_valid, mem_cmd_cas, mem_rsp_valid, mem_cas_ok;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_cmp, mem_wdata, mem_rdata;

  subword_rmw #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_addr(req_addr), .req_bitoff(req_bitoff), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_cas(mem_cmd_cas), .mem_addr(mem_addr),
    .mem_cmp(mem_cmp), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata), .mem_cas_ok(mem_cas_ok));

  logic [31:0] mem [16];
  int ncmd = 0, ncas = 0;
  logic        poke_en = 0;
  logic [3:0]  poke_idx = '0;
  logic [31:0] poke_val = '0;
  int          intf_n = 0, cas_base = 0;
  logic [31:0] intf_pat [2];

  always @(posedge clk) begin
    logic [31:0] cur;
    int k;
    mem_rsp_valid <= 1'b0;
    mem_cas_ok    <= 1'b0;
    if (poke_en) mem[poke_idx] <= poke_val;
    if (rst_n && mem_cmd_valid) begin
      ncmd <= ncmd + 1;
      cur = mem[mem_addr[3:0]];
      mem_rsp_valid <= 1'b1;
      if (mem_cmd_cas) begin
        ncas <= ncas + 1;
        k = ncas - cas_base;
        if (k < intf_n && k < 2) cur = cur ^ intf_pat[k];
        if (cur == mem_cmp) begin
          mem[mem_addr[3:0]] <= mem_wdata;
          mem_cas_ok <= 1'b1;
        end else begin
          mem[mem_addr[3:0]] <= cur;
        end
      end
      mem_rdata <= cur;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    @(negedge clk);
    poke_en = 1; poke_idx = idx[3:0]; poke_val = val;
    @(negedge clk);
    poke_en = 0;
  endtask

  task automatic issue(input logic st, input int addr, input int off, input logic [31:0] d,
                       input int hold, output logic [7:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_store = st; req_addr = addr[ADDR_W-1:0];
    req_bitoff = off[OFF_W-1:0]; req_data = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_data; er = rsp_err;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 rsp held valid", rsp_valid, 1);
      check("R8 rsp data stable", rsp_data, rd);
      check("R8 no new request", req_ready, 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic t_reset;
    check("R1 req_ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 mem_cmd_valid", mem_cmd_valid, 0);
  endtask

  task automatic t_load_lanes;
    logic [7:0] rd; logic er; int c0, s0;
    logic [31:0] w = 32'hA1B2C3D4;
    poke(3, w);
    for (int k = 0; k < 4; k++) begin
      c0 = ncmd; s0 = ncas;
      issue(0, 3, 8*k, 32'h0, 0, rd, er);
      check("R2 load lane byte", rd, (w >> (8*k)) & 32'hFF);
      check("R2 load err", er, 0);
      check("R3 one command", ncmd - c0, 1);
      check("R3 no exchange", ncas - s0, 0);
    end
  endtask

  task automatic t_store;
    logic [7:0] rd; logic er; int s0;
    poke(4, 32'h11223344);
    s0 = ncas;
    issue(1, 4, 16, 32'hFFFFFF5A, 0, rd, er);
    check("R4 R5 lane2 merge", mem[4], 32'h115A3344);
    check("R6 single exchange", ncas - s0, 1);
    check("R9 store err", er, 0);
    check("R9 store data", rd, 0);
    issue(1, 4, 0, 32'hABCDEF01, 0, rd, er);
    check("R5 lane0 merge", mem[4], 32'h115A3301);
    issue(1, 4, 24, 32'h000000C3, 0, rd, er);
    check("R4 lane3 merge", mem[4], 32'hC35A3301);
  endtask

  task automatic t_contention;
    logic [7:0] rd; logic er;
    poke(5, 32'h0);
    @(negedge clk);
    intf_pat[0] = 32'h000000AA;
    intf_pat[1] = 32'hFF000000;
    cas_base = ncas;
    intf_n = 2;
    issue(1, 5, 8, 32'h77, 0, rd, er);
    check("R6 retries until success", ncas - cas_base, 3);
    check("R6 concurrent lanes kept", mem[5], 32'hFF0077AA);
    check("R6 store err", er, 0);
    intf_n = 0;
  endtask

  task automatic t_bad_off;
    logic [7:0] rd; logic er; int c0;
    poke(6, 32'h5555AAAA);
    c0 = ncmd;
    issue(1, 6, 12, 32'hFF, 0, rd, er);
    check("R7 misaligned err", er, 1);
    issue(0, 6, 40, 32'h0, 0, rd, er);
    check("R7 out-of-range err", er, 1);
    check("R7 no memory command", ncmd - c0, 0);
    check("R7 memory unchanged", mem[6], 32'h5555AAAA);
  endtask

  task automatic t_hold;
    logic [7:0] rd; logic er;
    poke(7, 32'h00C00000);
    issue(0, 7, 16, 32'h0, 3, rd, er);
    check("R8 held load data", rd, 8'hC0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_load_lanes;
    t_store;
    t_contention;
    t_bad_off;
    t_hold;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule